// File: doc/BRIEF.md
# SAR Conversion Sequencing Controller

This block runs the conversion sequence of a 16-bit successive-approximation converter. A one-cycle start strobe begins a conversion. The block raises `busy` and holds it for a number of system clock cycles set by the selected speed mode. During the last `DATA_W` cycles of that window it makes one bit decision per cycle, most significant bit first. For each decision it places a trial code on `dac_code` and reads the single-bit comparator answer on `comp_in`.

The decided code is registered onto `result` on the same clock edge on which `busy` falls, so the data is ready with no extra pipeline stage. Three speed modes are available: fast, normal and low-power. Each has its own conversion length, and that length is fixed when the conversion starts.

Fast mode loses accuracy if the converter sits idle too long. For that case a sticky flag records when the idle gap in fast mode reaches a limit. A one-cycle clear input resets the flag. The power-down input lets the conversion in progress finish and then refuses new starts. The reset input aborts everything at once.

Top module: `sar_conv_seq`

## Requirements
- R1: A start strobe sampled high while `busy` is low, `pwr_down` is low and `rst` is low is accepted, and `busy` is high from the next clock edge.
- R2: `busy` stays high for exactly CYC_FAST cycles in fast mode, CYC_NORM cycles in normal mode and CYC_LOW cycles in low-power mode. Fast mode means `fast_sel`=1 and `lowpwr_sel`=0. Low-power mode means `lowpwr_sel`=1 and `fast_sel`=0. Any other combination is normal mode.
- R3: The decisions fill the last DATA_W cycles of the busy window, MSB first, one bit per cycle. In the decision for bit i, `dac_code` equals the bits already kept with bit i set. A high `comp_in` keeps bit i.
- R4: `result` takes the decided code on the edge where `busy` falls, and it holds its value at all other times.
- R5: `rst` high at a clock edge aborts any conversion. After that edge `busy`=0, `result`=0 and `timeout_flag`=0.
- R6: A start strobe that arrives while `busy` is high is ignored. The running conversion keeps its length and result, and no second conversion follows.
- R7: The mode inputs are sampled only when a start is accepted. Changing them during a conversion does not change its length.
- R8: While `pwr_down` is high, a conversion already running completes normally and start strobes are refused.
- R9: `timeout_flag` is set once IDLE_MAX idle cycles in fast mode have passed since the last accepted start or reset. It then stays set.
- R10: A high `clr_timeout` clears `timeout_flag` on the next edge. If the set condition occurs in the same cycle, the set wins.
- R11: Idle cycles in normal or low-power mode do not advance the idle count, so a long idle gap there never sets `timeout_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, aborts a conversion |
| conv_start | input | 1 | Start strobe |
| fast_sel | input | 1 | Fast mode select |
| lowpwr_sel | input | 1 | Low-power mode select |
| pwr_down | input | 1 | Refuse new conversions after the current one |
| comp_in | input | 1 | Comparator answer: 1 when input is at or above the trial code |
| clr_timeout | input | 1 | Clear strobe for the idle timeout flag |
| busy | output | 1 | High while a conversion runs |
| result | output | DATA_W | Last completed conversion code |
| dac_code | output | DATA_W | Trial code for the comparator |
| timeout_flag | output | 1 | Sticky flag: fast-mode idle limit reached |

## Verification
The hardest case to reach is a clear strobe landing on the very cycle in which the fast-mode idle count reaches its limit. The bench gets there by starting a fast conversion and waiting for `busy` to fall. It then counts exactly IDLE_MAX-1 idle cycles and raises `clr_timeout` for the next one. The idle limit is overridden to a small value so that this sits within a short run. A comparator model answers from the live `dac_code`, so every completed code must match the modelled input voltage.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_FAST   = 2'd1,
    SPD_LOWPWR = 2'd2
  } speed_e;

  function automatic speed_e pick_speed(input logic fast_in, input logic low_in);
    if (fast_in && !low_in)      return SPD_FAST;
    else if (low_in && !fast_in) return SPD_LOWPWR;
    else                         return SPD_NORMAL;
  endfunction
endpackage

// File: rtl/sar_speed_dec.sv
module sar_speed_dec
  import sar_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int CYC_FAST = 150,
  parameter int CYC_NORM = 175,
  parameter int CYC_LOW  = 200
) (
  input  logic             fast_sel,
  input  logic             lowpwr_sel,
  output logic [CNT_W-1:0] span,
  output logic             is_fast
);
  speed_e spd;

  always_comb begin
    spd = pick_speed(fast_sel, lowpwr_sel);
    unique case (spd)
      SPD_FAST:   span = CNT_W'(CYC_FAST);
      SPD_LOWPWR: span = CNT_W'(CYC_LOW);
      default:    span = CNT_W'(CYC_NORM);
    endcase
    is_fast = (spd == SPD_FAST);
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              begin_conv,
  input  logic              step_en,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              finish,
  input  logic              comp_in,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] trial_bit;

  always_comb begin
    trial_bit = '0;
    if (step_en) trial_bit[bit_idx] = 1'b1;
    dac_code = kept | trial_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kept   <= '0;
      result <= '0;
    end else begin
      if (begin_conv) kept <= '0;
      else if (step_en && comp_in) kept[bit_idx] <= 1'b1;
      if (finish) result <= kept | {{(DATA_W-1){1'b0}}, comp_in};
    end
  end

  // R3: bits at and below the current decision are still clear
  logic [DATA_W-1:0] low_part;
  assign low_part = kept << (IDX_W'(DATA_W - 1) - bit_idx);

  p_lower_clear_r3: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (low_part == '0));

  p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(result));
endmodule

// File: rtl/sar_idle_watch.sv
module sar_idle_watch #(
  parameter int IDLE_MAX = 100000,
  localparam int IDLE_W = $clog2(IDLE_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic begin_conv,
  input  logic busy,
  input  logic is_fast,
  input  logic clr_timeout,
  output logic timeout_flag
);
  logic [IDLE_W-1:0] idle_cnt;
  logic              reach;

  assign reach = !busy && !begin_conv && is_fast &&
                 (idle_cnt == IDLE_W'(IDLE_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt     <= '0;
      timeout_flag <= 1'b0;
    end else begin
      if (begin_conv) idle_cnt <= '0;
      else if (!busy && is_fast && idle_cnt != IDLE_W'(IDLE_MAX))
        idle_cnt <= idle_cnt + 1'b1;
      if (reach)            timeout_flag <= 1'b1;
      else if (clr_timeout) timeout_flag <= 1'b0;
    end
  end

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_timeout && !reach) |=> !timeout_flag);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !clr_timeout) |=> timeout_flag);

  p_slow_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!is_fast && !begin_conv) |=> $stable(idle_cnt));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int DATA_W   = 16,
  parameter int CYC_FAST = 150,
  parameter int CYC_NORM = 175,
  parameter int CYC_LOW  = 200,
  parameter int IDLE_MAX = 100000,
  localparam int CYC_MAX = (CYC_FAST > CYC_NORM) ?
                           ((CYC_FAST > CYC_LOW) ? CYC_FAST : CYC_LOW) :
                           ((CYC_NORM > CYC_LOW) ? CYC_NORM : CYC_LOW),
  localparam int CNT_W = $clog2(CYC_MAX + 1),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              fast_sel,
  input  logic              lowpwr_sel,
  input  logic              pwr_down,
  input  logic              comp_in,
  input  logic              clr_timeout,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] dac_code,
  output logic              timeout_flag
);
  logic [CNT_W-1:0] span;
  logic             is_fast;
  logic [CNT_W-1:0] remain;
  logic             accept;
  logic             step_en;
  logic             finish;

  sar_speed_dec #(
    .CNT_W(CNT_W), .CYC_FAST(CYC_FAST), .CYC_NORM(CYC_NORM), .CYC_LOW(CYC_LOW)
  ) u_dec (
    .fast_sel(fast_sel), .lowpwr_sel(lowpwr_sel), .span(span), .is_fast(is_fast)
  );

  assign accept  = conv_start && !busy && !pwr_down;
  assign step_en = busy && (remain < CNT_W'(DATA_W));
  assign finish  = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      remain <= span - 1'b1;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  sar_bit_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .begin_conv(accept), .step_en(step_en),
    .bit_idx(remain[IDX_W-1:0]), .finish(finish), .comp_in(comp_in),
    .dac_code(dac_code), .result(result)
  );

  sar_idle_watch #(.IDLE_MAX(IDLE_MAX)) u_idle (
    .clk(clk), .rst(rst), .begin_conv(accept), .busy(busy), .is_fast(is_fast),
    .clr_timeout(clr_timeout), .timeout_flag(timeout_flag)
  );

  p_busy_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !busy && !pwr_down) |=> busy);

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && remain != '0) |=> busy);

  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_start && remain != '0) |=> (remain == $past(remain) - 1'b1));

  p_reset_abort_r5: assert property (@(posedge clk)
    rst |=> (!busy && result == '0 && !timeout_flag));

  p_pd_block_r8: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && !busy) |=> !busy);
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  localparam int W  = 16;
  localparam int CF = 150;
  localparam int CN = 175;
  localparam int CL = 200;
  localparam int IM = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0, fast_sel = 1'b0, lowpwr_sel = 1'b0;
  logic pwr_down = 1'b0, clr_timeout = 1'b0;
  logic comp_in;
  logic busy, timeout_flag;
  logic [W-1:0] result, dac_code;
  logic [W-1:0] vin = '0;

  int total = 0;
  int bad = 0;

  typedef struct { logic [W-1:0] code; int cyc; string tag; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  assign comp_in = (dac_code <= vin);

  sar_conv_seq #(.DATA_W(W), .CYC_FAST(CF), .CYC_NORM(CN), .CYC_LOW(CL),
                 .IDLE_MAX(IM)) u0 (
    .clk(clk), .rst(rst), .conv_start(conv_start), .fast_sel(fast_sel),
    .lowpwr_sel(lowpwr_sel), .pwr_down(pwr_down), .comp_in(comp_in),
    .clr_timeout(clr_timeout), .busy(busy), .result(result),
    .dac_code(dac_code), .timeout_flag(timeout_flag)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: measures each busy window and compares against the queue
  int run_len = 0;
  always @(negedge clk) begin
    if (rst) run_len = 0;
    else if (busy) run_len++;
    else if (run_len > 0) begin
      if (sb_q.size() == 0) chk(1'b0, "R6 unexpected conversion", run_len, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(result == e.code, {e.tag, " R3 R4 result"}, result, e.code);
        chk(run_len == e.cyc, {e.tag, " R2 busy length"}, run_len, e.cyc);
      end
      run_len = 0;
    end
  end

  task automatic kick(input logic [W-1:0] v, input bit f, input bit l, input int cyc, input string tag);
    exp_t e;
    vin = v; fast_sel = f; lowpwr_sel = l;
    e.code = v; e.cyc = cyc; e.tag = tag;
    sb_q.push_back(e);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
  endtask

  task automatic convert(input logic [W-1:0] v, input bit f, input bit l, input int cyc, input string tag);
    kick(v, f, l, cyc, tag);
    wait_done();
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 0, "R5 reset busy", busy, 0);
    chk(result == 0, "R5 reset result", result, 0);
    chk(timeout_flag == 0, "R5 reset flag", timeout_flag, 0);

    // R2 R3 R4: mode decode and codes
    convert(16'h0000, 0, 0, CN, "normal zero");
    convert(16'hFFFF, 0, 0, CN, "normal full");
    convert(16'hA5C3, 1, 0, CF, "fast a5c3");
    convert(16'h8000, 1, 0, CF, "fast 8000");
    convert(16'h7FFF, 0, 1, CL, "low 7fff");
    convert(16'h1234, 0, 1, CL, "low 1234");
    convert(16'h0001, 1, 1, CN, "both-high normal");

    // R3: MSB-first trial codes
    kick(16'hC000, 0, 0, CN, "msb order");
    repeat (CN - 16) @(negedge clk);
    chk(dac_code == 16'h8000, "R3 first trial", dac_code, 16'h8000);
    @(negedge clk);
    chk(dac_code == 16'hC000, "R3 second trial", dac_code, 16'hC000);
    @(negedge clk);
    chk(dac_code == 16'hE000, "R3 third trial", dac_code, 16'hE000);
    wait_done();

    // R6 R7: strobe and mode change during busy
    kick(16'h3C5A, 1, 0, CF, "R6 R7 fast");
    repeat (20) @(negedge clk);
    fast_sel = 1'b0; lowpwr_sel = 1'b1;
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    wait_done();
    @(negedge clk);
    chk(busy == 0, "R6 no second conversion", busy, 0);

    // R8: power-down lets running conversion finish, then blocks
    kick(16'h4321, 0, 0, CN, "R8 finish");
    repeat (10) @(negedge clk);
    pwr_down = 1'b1;
    wait_done();
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R8 start refused", busy, 0);
    pwr_down = 1'b0;
    convert(16'h0F0F, 0, 0, CN, "R8 after release");

    // R5: abort mid-conversion
    vin = 16'hFFFF; conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0, "R5 abort busy", busy, 0);
    chk(result == 0, "R5 abort result", result, 0);
    rst = 1'b0;
    @(negedge clk);

    // R9: fast idle limit
    convert(16'h5555, 1, 0, CF, "R9 fast");
    repeat (IM - 1) @(negedge clk);
    chk(timeout_flag == 0, "R9 one short of limit", timeout_flag, 0);
    @(negedge clk);
    chk(timeout_flag == 1, "R9 limit reached", timeout_flag, 1);
    repeat (10) @(negedge clk);
    chk(timeout_flag == 1, "R9 sticky", timeout_flag, 1);

    // R10: clear, no re-set while saturated
    clr_timeout = 1'b1;
    @(negedge clk);
    clr_timeout = 1'b0;
    chk(timeout_flag == 0, "R10 cleared", timeout_flag, 0);
    repeat (10) @(negedge clk);
    chk(timeout_flag == 0, "R10 stays clear", timeout_flag, 0);

    // R10: set wins over clear in the same cycle
    convert(16'hAAAA, 1, 0, CF, "R10 fast");
    repeat (IM - 1) @(negedge clk);
    clr_timeout = 1'b1;
    @(negedge clk);
    clr_timeout = 1'b0;
    chk(timeout_flag == 1, "R10 set wins", timeout_flag, 1);
    clr_timeout = 1'b1;
    @(negedge clk);
    clr_timeout = 1'b0;

    // R11: long idle in low-power mode
    convert(16'h00FF, 0, 1, CL, "R11 low");
    repeat (IM + 100) @(negedge clk);
    chk(timeout_flag == 0, "R11 no timeout in low-power", timeout_flag, 0);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule